// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the host-facing end of a small timekeeping device. A host talks to it over three wires: an active-high enable, a serial clock and one data line that the block drives only while it returns read data. The data line is split here into an input and an output with an output enable, so the pad buffer can sit outside. All three pins are synchronized into the system clock, and serial clock edges are found in that domain.

Each transfer opens with a command byte that is shifted in least-significant bit first. The byte chooses one of two register spaces, an address within it, the direction, and whether writes are allowed. Data bytes follow, also least-significant bit first. One address value selects a burst that walks the space from index zero. The calendar space is reached through a simple parallel register bus toward the counters. The general-purpose space is a 31-byte memory held inside the block.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, and while enable is low, `sdio_oe` and `reg_we` are 0.
- R2: Command byte bits are taken in arrival order as bit 0 first. Bit 0 is the direction (1 = read). Bits 5..1 are the address. Bit 6 selects the RAM space when 1 and the calendar space when 0. Bit 7 is the write permit.
- R3: A single-byte calendar write gives exactly one one-cycle `reg_we` pulse, carrying the command address on `reg_addr` and the data byte assembled from bits in arrival order, bit 0 first.
- R4: A single-byte read drives the addressed byte bit 0 first, one bit per falling serial clock edge. The first bit goes out on the falling edge that follows the last command bit. RAM writes are readable this way.
- R5: With command bit 7 at 0, no write reaches either space. Reads still return data.
- R6: Address 31 in the RAM space starts a burst at index 0 that advances after every byte and covers indices 0..30.
- R7: Address 31 in the calendar space bursts over indices 0..CLK_REGS-1 (default 8). Bytes beyond that range are not written.
- R8: When a burst read has passed its last index, the data line is released (`sdio_oe` = 0) and stays released.
- R9: Dropping enable in the middle of a command or data byte discards it. Nothing is written, and the next transfer decodes a fresh command.
- R10: `sdio_oe` falls within four system clocks of enable going low, and it only rises while enable is high.
- R11: A single-byte transfer handles one data byte only. Further write bytes are dropped, and after the read byte the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Serial chip enable, active high |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad output enable |
| reg_addr | output | 5 | Calendar register index |
| reg_we | output | 1 | One-cycle calendar write strobe |
| reg_wdata | output | 8 | Calendar write data |
| reg_rdata | input | 8 | Calendar read data for `reg_addr` |

## Verification
Every pin passes through a two-stage synchronizer, and the control state sits one register after that. A serial clock edge therefore reaches `sdio_out`, `sdio_oe`, `reg_we` or the RAM three system clocks after it appears at the pin. The bench holds each serial clock level for eight system clocks and samples read data just before it raises the serial clock, which is five clocks after the due cycle. Calendar writes are judged after the transfer ends, from a bench register model that is updated on `reg_we`. The release after the last byte is checked one falling edge later.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[STAGES-2:0], din[i]};
        end
        assign dout[i] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/tw_ram.sv
module tw_ram #(
    parameter int DEPTH = 31,
    parameter int AW    = 5,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam logic [AW:0] LIM = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIM)) mem[waddr] <= wdata;
    end

    assign rdata = ({1'b0, raddr} < LIM) ? mem[raddr] : '0;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
    parameter int DW        = 8,
    parameter int AW        = 5,
    parameter int RAM_DEPTH = 31,
    parameter int CLK_REGS  = 8,
    parameter int SYNC      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          sclk,
    input  logic          sdio_in,
    output logic          sdio_out,
    output logic          sdio_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    import tw_pkg::*;

    localparam int            CW        = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT  = CW'(DW-1);
    localparam logic [AW-1:0] BURST_IDX = '1;
    localparam logic [AW:0]   RAM_LIM   = (AW+1)'(RAM_DEPTH);
    localparam logic [AW:0]   CLK_LIM   = (AW+1)'(CLK_REGS);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] bcnt;
        logic [DW-1:0] sh;
        logic          rd;
        logic          ram;
        logic          wen;
        logic          burst;
        logic          more;
        logic [AW-1:0] idx;
        logic [AW-1:0] baddr;
        logic          bwe;
        logic          rwe;
        logic [DW-1:0] bwdata;
        logic          oe;
        logic          dout;
        logic          sclk_prev;
    } ctl_t;

    ctl_t q, d;

    logic [2:0]    pins_s;
    logic          ce_s, sclk_s, sdi_s;
    logic          sclk_rise, sclk_fall;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] rd_byte;
    logic [DW-1:0] byte_in;
    logic [AW:0]   lim;
    logic          in_rng;
    logic          ram_we;

    tw_sync #(.W(3), .STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdio_in, sclk, ce}),
        .dout (pins_s)
    );
    assign ce_s   = pins_s[0];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[2];

    tw_ram #(.DEPTH(RAM_DEPTH), .AW(AW), .DW(DW)) u_ram (
        .clk  (clk),
        .we   (q.rwe),
        .waddr(q.baddr),
        .wdata(q.bwdata),
        .raddr(q.idx),
        .rdata(ram_rdata)
    );

    assign sclk_rise = sclk_s & ~q.sclk_prev;
    assign sclk_fall = ~sclk_s & q.sclk_prev;
    assign byte_in   = {sdi_s, q.sh[DW-1:1]};
    assign lim       = q.ram ? RAM_LIM : CLK_LIM;
    assign in_rng    = !q.burst || ({1'b0, q.idx} < lim);
    assign rd_byte   = q.ram ? ram_rdata : reg_rdata;

    always_comb begin
        d           = q;
        d.bwe       = 1'b0;
        d.rwe       = 1'b0;
        d.sclk_prev = sclk_s;
        if (!ce_s) begin
            d           = '0;
            d.sclk_prev = sclk_s;
            d.baddr     = q.baddr;
        end else begin
            unique case (q.phase)
                PH_CMD: if (sclk_rise) begin
                    d.sh   = byte_in;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == LAST_BIT) begin
                        // command fields, bit 0 arrived first
                        d.rd    = byte_in[0];
                        d.ram   = byte_in[DW-2];
                        d.wen   = byte_in[DW-1];
                        d.burst = (byte_in[AW:1] == BURST_IDX);
                        d.idx   = d.burst ? '0 : byte_in[AW:1];
                        d.more  = 1'b1;
                        d.bcnt  = '0;
                        d.phase = byte_in[0] ? PH_RD : PH_WR;
                    end
                end
                PH_WR: if (sclk_rise) begin
                    d.sh   = byte_in;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == LAST_BIT) begin
                        if (q.more && in_rng && q.wen) begin
                            d.rwe    = q.ram;
                            d.bwe    = !q.ram;
                            d.bwdata = byte_in;
                            d.baddr  = q.idx;
                        end
                        if (q.burst && in_rng) d.idx  = q.idx + 1'b1;
                        else                   d.more = 1'b0;
                    end
                end
                PH_RD: if (sclk_fall) begin
                    if (q.bcnt == '0) begin
                        if (q.more && in_rng) begin
                            d.oe   = 1'b1;
                            d.dout = rd_byte[0];
                            d.sh   = rd_byte >> 1;
                            d.bcnt = 1;
                        end else begin
                            d.oe    = 1'b0;
                            d.dout  = 1'b0;
                            d.phase = PH_DONE;
                        end
                    end else begin
                        d.dout = q.sh[0];
                        d.sh   = q.sh >> 1;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == LAST_BIT) begin
                            if (q.burst) d.idx  = q.idx + 1'b1;
                            else         d.more = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (!(d.bwe || d.rwe)) d.baddr = d.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ram_we    = q.rwe;
    assign sdio_out  = q.oe & q.dout;
    assign sdio_oe   = q.oe;
    assign reg_addr  = q.baddr;
    assign reg_we    = q.bwe;
    assign reg_wdata = q.bwdata;
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic          sdio_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic          ram_we
);
    // R10
    ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && $past(!ce) && $past(!ce, 2) && $past(!ce, 3) && $past(!ce, 4)) |-> !sdio_oe);

    // R10
    drive_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> ce);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr != '1));

    // R2
    one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, ram_we}));

    // R8
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || ram_we) |-> !sdio_oe);
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .sdio_oe (sdio_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .ram_we  (ram_we)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic       sdio_out, sdio_oe, reg_we;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] tk [32];
    logic [7:0] exp_tk [32];
    logic [7:0] exp_ram [31];
    int we_count = 0;
    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tw_reg_slave i_tw_reg_slave (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdio_in(sdi),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = tk[reg_addr];
    always @(posedge clk) if (reg_we) begin
        tk[reg_addr] <= reg_wdata;
        we_count     <= we_count + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdi = b; tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0;
    endtask

    task automatic rbit(output logic b, output logic oe);
        tick(HP); b = sdio_out; oe = sdio_oe; sclk = 1'b1; tick(HP); sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) sbit(v[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v, output int oe_cnt);
        logic b, oe;
        oe_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            rbit(b, oe); v[i] = b; oe_cnt += int'(oe);
        end
    endtask

    task automatic begin_xfer(); ce = 1'b1; tick(HP); endtask
    task automatic end_xfer(); tick(HP); ce = 1'b0; tick(3 * HP); endtask

    function automatic logic [7:0] cmd(input logic wen, input logic ram,
                                       input logic [4:0] a, input logic rd);
        return {wen, ram, a, rd};
    endfunction

    task automatic wr1(input logic ram, input logic [4:0] a, input logic [7:0] v, input logic wen);
        begin_xfer(); send_byte(cmd(wen, ram, a, 1'b0)); send_byte(v); end_xfer();
        if (wen) begin
            if (ram) exp_ram[a] = v; else exp_tk[a] = v;
        end
    endtask

    task automatic rd1(input logic ram, input logic [4:0] a, output logic [7:0] v,
                       output int oe_cnt, output logic oe_after);
        logic b;
        begin_xfer(); send_byte(cmd(1'b1, ram, a, 1'b1));
        recv_byte(v, oe_cnt); rbit(b, oe_after); end_xfer();
    endtask

    initial begin
        tick(150000);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!finished) $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v, bv[32];
        logic oe_after, b, oe;
        int oc, wc0;
        void'($urandom(32'd7717));
        for (int i = 0; i < 32; i++) begin tk[i] = 8'h00; exp_tk[i] = 8'h00; end
        tick(5); rst_n = 1'b1; tick(5);
        check("R1 oe after reset", sdio_oe, 0);
        check("R1 we after reset", reg_we, 0);

        // R6 burst RAM write then burst read
        begin_xfer(); send_byte(cmd(1, 1, 5'd31, 0));
        for (int i = 0; i < 31; i++) begin
            v = 8'($urandom); exp_ram[i] = v; send_byte(v);
        end
        end_xfer();
        begin_xfer(); send_byte(cmd(1, 1, 5'd31, 1));
        for (int i = 0; i < 31; i++) begin
            recv_byte(v, oc);
            check("R6 burst ram data", v, exp_ram[i]);
            if (i == 0 || i == 30) check("R4 oe during read byte", oc, 8);
        end
        rbit(b, oe); check("R8 release after burst end", oe, 0);
        rbit(b, oe); check("R8 stays released", oe, 0);
        end_xfer();
        check("R10 oe with ce low", sdio_oe, 0);

        // R3 single calendar write
        wc0 = we_count;
        wr1(0, 5'd3, 8'hA5, 1);
        check("R3 one write pulse", we_count - wc0, 1);
        check("R3 calendar data", tk[3], 8'hA5);
        rd1(0, 5'd3, v, oc, oe_after);
        check("R4 calendar read", v, 8'hA5);
        check("R11 release after single read", oe_after, 0);

        // R4 RAM single write/read at both ends
        wr1(1, 5'd0, 8'h3C, 1);
        rd1(1, 5'd0, v, oc, oe_after); check("R4 ram addr 0", v, 8'h3C);
        wr1(1, 5'd30, 8'hC1, 1);
        rd1(1, 5'd30, v, oc, oe_after); check("R4 ram addr 30", v, 8'hC1);

        // R5 write permit cleared
        wr1(1, 5'd0, 8'h55, 0);
        rd1(1, 5'd0, v, oc, oe_after); check("R5 ram unchanged", v, 8'h3C);
        wc0 = we_count;
        wr1(0, 5'd3, 8'h11, 0);
        check("R5 no calendar pulse", we_count - wc0, 0);
        check("R5 calendar unchanged", tk[3], 8'hA5);

        // R7 calendar burst of 10 bytes, only 8 land
        wc0 = we_count;
        begin_xfer(); send_byte(cmd(1, 0, 5'd31, 0));
        for (int i = 0; i < 10; i++) begin
            bv[i] = 8'($urandom); send_byte(bv[i]);
            if (i < 8) exp_tk[i] = bv[i];
        end
        end_xfer();
        check("R7 pulse count", we_count - wc0, 8);
        for (int i = 0; i < 10; i++) check("R7 calendar content", tk[i], exp_tk[i]);
        begin_xfer(); send_byte(cmd(1, 0, 5'd31, 1));
        for (int i = 0; i < 8; i++) begin
            recv_byte(v, oc); check("R7 calendar burst read", v, exp_tk[i]);
        end
        rbit(b, oe); check("R8 release after calendar burst", oe, 0);
        end_xfer();

        // R11 extra write byte dropped
        begin_xfer(); send_byte(cmd(1, 1, 5'd2, 0)); send_byte(8'h9E); send_byte(8'h44); end_xfer();
        exp_ram[2] = 8'h9E;
        rd1(1, 5'd2, v, oc, oe_after); check("R11 first byte kept", v, 8'h9E);
        rd1(1, 5'd3, v, oc, oe_after); check("R11 neighbour untouched", v, exp_ram[3]);

        // R9 aborts
        begin_xfer(); send_byte(cmd(1, 1, 5'd4, 0));
        for (int i = 0; i < 5; i++) sbit(1'b1);
        end_xfer();
        rd1(1, 5'd4, v, oc, oe_after); check("R9 partial data dropped", v, exp_ram[4]);
        begin_xfer(); for (int i = 0; i < 4; i++) sbit(1'b0); end_xfer();
        rd1(1, 5'd4, v, oc, oe_after); check("R9 fresh command decode", v, exp_ram[4]);
        begin_xfer(); send_byte(cmd(1, 1, 5'd4, 1));
        for (int i = 0; i < 3; i++) rbit(b, oe);
        ce = 1'b0; tick(4);
        check("R10 oe drops on abort", sdio_oe, 0);
        tick(3 * HP);

        // R2 random mix over both spaces
        for (int n = 0; n < 40; n++) begin
            automatic int op = int'($urandom % 4);
            automatic logic [4:0] a = 5'($urandom % 31);
            automatic logic [7:0] d = 8'($urandom);
            case (op)
                0: wr1(1, a, d, 1);
                1: begin rd1(1, a, v, oc, oe_after); check("R2 random ram read", v, exp_ram[a]); end
                2: begin wr1(0, a, d, 1); check("R3 random calendar write", tk[a], d); end
                default: begin rd1(0, a, v, oc, oe_after); check("R2 random calendar read", v, exp_tk[a]); end
            endcase
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule